// File: doc/BRIEF.md
# Quadrature Encoder Sampler and Decoder

This block watches the two phase lines of a mechanical rotary encoder. Both lines are synchronised to the core clock and then read whenever the sample tick is high. The tick rate is set much faster than the shaft can turn, so that each contact bounce edge is observed. A reading that matches the previous one is thrown away. Each reading that differs is stored in a packing register holding sixteen 2-bit slots. A full register is offered as a 32-bit word on a valid/ready output, together with a count of the slots it holds. A flush request pushes out a partly filled register at once, so that a consumer polling the encoder always receives current data.

The same stream of changed readings drives a Gray-code position tracker. It issues a single step pulse, marked with a direction flag, each time the shaft goes through one complete four-state cycle and comes back to the rest state. If the shaft backs off partway, nothing is issued. If a reading jumps two positions at once, it is discarded. Together these rules keep bounce from producing any step.

Top module: `qenc_sampler_top`

## Requirements
- R1: Each reading is `{pin_a, pin_b}` (pin_a in bit 1) taken after a two-flop synchroniser. A reading is taken only on a clock edge where `sample_tick` is 1. Pin changes made while the tick is low have no effect until a later tick.
- R2: A reading equal to the previous accepted reading is dropped and uses no slot. The previous reading is 2'b00 after reset.
- R3: Slot i of a word occupies bits [2i+1:2i] of `word_data`. Slot 0 holds the oldest reading.
- R4: When the sixteenth slot fills and the output is free, the word appears on the output with `word_count` = 16.
- R5: A one-cycle `flush_req` while 1 to 15 slots are filled emits the partial word with `word_count` equal to the fill level, and all unused slots are zero. A flush while nothing is stored emits nothing.
- R6: While `word_valid` is 1 and `word_ready` is 0, `word_data` and `word_count` stay unchanged. A cycle with both high consumes the word.
- R7: A changed reading that arrives while the output is busy and the packing register is full is dropped and sets `overflow`. The flag stays set until reset. The full register is moved to the output as soon as the output frees.
- R8: The decoder position follows 00→01→11→10→00. A full forward cycle ending at 00 gives one cycle of `step_pulse` with `step_dir` = 1.
- R9: A full cycle in the reverse order (00→10→11→01→00) gives one pulse with `step_dir` = 0.
- R10: Returning to 00 before a full cycle completes (a reversal or a bounce) emits no pulse and clears the progress count.
- R11: A reading two positions away from the current position (for example 00→11) is ignored by the decoder, and its state does not change.
- R12: After synchronous reset, `word_valid`, `overflow` and `step_pulse` are 0 and `word_count` is 0.

Top module parameters: `SLOTS` (slots per word) and `SYNC_STAGES` (synchroniser depth).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Sample enable; a reading is taken on each edge where it is high |
| pin_a | input | 1 | Raw encoder phase line, becomes reading bit 1 |
| pin_b | input | 1 | Raw encoder phase line, becomes reading bit 0 |
| flush_req | input | 1 | Push out a partial word |
| word_data | output | 32 | Packed readings, slot i at bits [2i+1:2i] |
| word_count | output | 5 | Number of valid slots in `word_data` |
| word_valid | output | 1 | Word on output is valid |
| word_ready | input | 1 | Consumer accepts the word |
| overflow | output | 1 | Sticky flag set when a changed reading was dropped |
| step_pulse | output | 1 | One-cycle pulse per completed detent cycle |
| step_dir | output | 1 | Direction of the last step, 1 forward |

## Verification
If the change detector's stored reading is wrong, a repeated reading shows up as an extra slot, or a real change goes missing. This appears in `word_count` on the next flush, a few cycles later. If the slot counter is wrong, a readable slot lands in the wrong position or the word leaves too early, which shows in `word_data` at once. If the decoder's progress count is corrupt, it produces a step after a bounce or misses a step after a real cycle, within four readings. A lost hold condition changes a stalled word on the very next edge.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int SAMPLE_W = 2;
  localparam int PHASES   = 4;
  typedef logic [SAMPLE_W-1:0] sample_t;

  // Gray reading to linear position along 00,01,11,10
  function automatic logic [1:0] gray_to_pos(input sample_t s);
    return {s[1], s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/qenc_packer.sv
module qenc_packer
  import qenc_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int WORD_W = SLOTS * SAMPLE_W,
  parameter int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  sample_t           in_sample,
  input  logic              flush_req,
  output logic [WORD_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              overflow
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

  logic [WORD_W-1:0] pack_q, base_data, nxt_data;
  logic [CNT_W-1:0]  cnt_q, base_cnt, nxt_cnt;
  logic              pend_q, ovf_q;
  logic              out_free, drain, ins, want_flush, emit;

  always_comb begin
    out_free   = !out_valid || out_ready;
    drain      = (cnt_q == FULL) && out_free;
    base_data  = drain ? '0 : pack_q;
    base_cnt   = drain ? '0 : cnt_q;
    ins        = in_valid && (base_cnt < FULL);
    nxt_data   = base_data;
    if (ins) nxt_data[int'(base_cnt) * SAMPLE_W +: SAMPLE_W] = in_sample;
    nxt_cnt    = base_cnt + CNT_W'(ins);
    want_flush = flush_req || pend_q;
    emit       = !drain && out_free &&
                 ((nxt_cnt == FULL) || (want_flush && (nxt_cnt != '0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pack_q    <= '0;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      ovf_q     <= 1'b0;
      out_data  <= '0;
      out_count <= '0;
      out_valid <= 1'b0;
    end else begin
      if (drain) begin
        out_data  <= pack_q;
        out_count <= cnt_q;
        out_valid <= 1'b1;
      end else if (emit) begin
        out_data  <= nxt_data;
        out_count <= nxt_cnt;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      pack_q <= emit ? '0 : nxt_data;
      cnt_q  <= emit ? '0 : nxt_cnt;
      pend_q <= want_flush && !emit && (nxt_cnt != '0);
      if (in_valid && !ins) ovf_q <= 1'b1;
    end
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
  import qenc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  input  sample_t in_sample,
  output logic    step_pulse,
  output logic    step_dir
);
  localparam logic signed [3:0] CYCLE_FWD = 4'sd4;
  localparam logic signed [3:0] CYCLE_BWD = -4'sd4;

  logic [1:0]        pos_q, new_pos, delta;
  logic signed [3:0] prog_q, prog_n;
  logic              fwd, bwd, at_rest;

  always_comb begin
    new_pos = gray_to_pos(in_sample);
    delta   = new_pos - pos_q;
    fwd     = (delta == 2'd1);
    bwd     = (delta == 2'(PHASES - 1));
    prog_n  = prog_q + (fwd ? 4'sd1 : -4'sd1);
    at_rest = (new_pos == 2'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      prog_q     <= '0;
      step_pulse <= 1'b0;
      step_dir   <= 1'b0;
    end else begin
      step_pulse <= 1'b0;
      if (in_valid && (fwd || bwd)) begin
        pos_q <= new_pos;
        if (at_rest) begin
          prog_q <= '0;
          if (prog_n == CYCLE_FWD) begin
            step_pulse <= 1'b1;
            step_dir   <= 1'b1;
          end else if (prog_n == CYCLE_BWD) begin
            step_pulse <= 1'b1;
            step_dir   <= 1'b0;
          end
        end else begin
          prog_q <= prog_n;
        end
      end
    end
  end
endmodule

// File: rtl/qenc_sampler_top.sv
module qenc_sampler_top
  import qenc_pkg::*;
#(
  parameter int SLOTS       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = SLOTS * SAMPLE_W,
  localparam int CNT_W      = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              flush_req,
  output logic [WORD_W-1:0] word_data,
  output logic [CNT_W-1:0]  word_count,
  output logic              word_valid,
  input  logic              word_ready,
  output logic              overflow,
  output logic              step_pulse,
  output logic              step_dir
);
  sample_t sync_s, last_q;
  logic    accept;

  qenc_sync #(.W(SAMPLE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({pin_a, pin_b}),
    .dout(sync_s)
  );

  // Change detection against the last reading taken
  assign accept = sample_tick && (sync_s != last_q);

  always_ff @(posedge clk) begin
    if (rst)              last_q <= '0;
    else if (sample_tick) last_q <= sync_s;
  end

  qenc_packer #(.SLOTS(SLOTS)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .in_valid (accept),
    .in_sample(sync_s),
    .flush_req(flush_req),
    .out_data (word_data),
    .out_count(word_count),
    .out_valid(word_valid),
    .out_ready(word_ready),
    .overflow (overflow)
  );

  qenc_decoder u_dec (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (accept),
    .in_sample (sync_s),
    .step_pulse(step_pulse),
    .step_dir  (step_dir)
  );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int SLOTS  = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_tick,
  input logic [WORD_W-1:0] word_data,
  input logic [CNT_W-1:0]  word_count,
  input logic              word_valid,
  input logic              word_ready,
  input logic              overflow,
  input logic              step_pulse
);
  p_reset_r12: assert property (@(posedge clk)
    rst |=> (!word_valid && !step_pulse && !overflow));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data) && $stable(word_count)));

  p_no_overflow_clear_r7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_count_range_r4: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ((word_count != '0) && (int'(word_count) <= SLOTS)));

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ((word_data >> (2 * int'(word_count))) == '0));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse);

  p_pulse_after_tick_r1: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> $past(sample_tick));
endmodule

bind qenc_sampler_top qenc_checker #(.SLOTS(SLOTS), .WORD_W(WORD_W), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .sample_tick(sample_tick),
  .word_data  (word_data),
  .word_count (word_count),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .overflow   (overflow),
  .step_pulse (step_pulse)
);

// File: tb/test_qenc_sampler_top.sv
`timescale 1ns/1ps
module test_qenc_sampler_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_tick = 1'b1;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic        flush_req = 1'b0;
  logic        word_ready = 1'b0;
  logic [31:0] word_data;
  logic [4:0]  word_count;
  logic        word_valid, overflow, step_pulse, step_dir;

  int n_checks = 0, n_fail = 0;
  int fwd_cnt = 0, bwd_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qenc_sampler_top i_qenc_sampler_top (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .pin_a(pin_a), .pin_b(pin_b),
    .flush_req(flush_req), .word_data(word_data), .word_count(word_count),
    .word_valid(word_valid), .word_ready(word_ready), .overflow(overflow),
    .step_pulse(step_pulse), .step_dir(step_dir)
  );

  always @(posedge clk) begin
    if (!rst && step_pulse) begin
      if (step_dir) fwd_cnt++;
      else          bwd_cnt++;
    end
  end

  function automatic logic [1:0] gray(input int k);
    logic [1:0] b = 2'(k);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] exp_word(input int first, input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) w[2*i +: 2] = gray(first + i);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s);
    @(negedge clk);
    {pin_a, pin_b} = s;
    repeat (5) @(negedge clk);
  endtask

  task automatic flush_pulse();
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic ready_pulse();
    @(negedge clk); word_ready = 1'b1;
    @(negedge clk); word_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; {pin_a, pin_b} = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int f0, b0;
    do_reset();
    // R12 reset state
    chk(!word_valid, "R12 valid", word_valid, 0);
    chk(!overflow, "R12 overflow", overflow, 0);
    chk(!step_pulse, "R12 pulse", step_pulse, 0);
    chk(word_count == 0, "R12 count", word_count, 0);

    // Decoder section, output always consumed
    word_ready = 1'b1;
    f0 = fwd_cnt; b0 = bwd_cnt;
    for (int k = 1; k <= 12; k++) drive(gray(k));
    chk(fwd_cnt - f0 == 3, "R8 forward steps", fwd_cnt - f0, 3);
    chk(step_dir == 1'b1, "R8 dir", step_dir, 1);
    chk(bwd_cnt == b0, "R8 no reverse", bwd_cnt - b0, 0);

    f0 = fwd_cnt; b0 = bwd_cnt;
    for (int k = 7; k >= 0; k--) drive(gray(k));
    chk(bwd_cnt - b0 == 2, "R9 reverse steps", bwd_cnt - b0, 2);
    chk(step_dir == 1'b0, "R9 dir", step_dir, 0);

    f0 = fwd_cnt; b0 = bwd_cnt;
    drive(2'b01); drive(2'b11); drive(2'b01); drive(2'b00);
    chk(fwd_cnt == f0 && bwd_cnt == b0, "R10 reversal", fwd_cnt + bwd_cnt - f0 - b0, 0);
    drive(2'b01); drive(2'b00); drive(2'b01); drive(2'b11); drive(2'b10); drive(2'b00);
    chk(fwd_cnt - f0 == 1 && bwd_cnt == b0, "R10 bounce", fwd_cnt - f0, 1);

    f0 = fwd_cnt; b0 = bwd_cnt;
    drive(2'b11); drive(2'b00);
    chk(fwd_cnt == f0 && bwd_cnt == b0, "R11 jump at rest", fwd_cnt + bwd_cnt - f0 - b0, 0);
    drive(2'b01); drive(2'b10); drive(2'b11); drive(2'b10); drive(2'b00);
    chk(fwd_cnt - f0 == 1 && bwd_cnt == b0, "R11 jump mid cycle", fwd_cnt - f0, 1);

    // Packing section
    word_ready = 1'b0;
    do_reset();
    sample_tick = 1'b0;
    @(negedge clk); {pin_a, pin_b} = 2'b01;
    repeat (6) @(negedge clk);
    flush_pulse();
    chk(!word_valid, "R1 no tick no sample", word_valid, 0);
    sample_tick = 1'b1;
    repeat (5) @(negedge clk);
    flush_pulse();
    chk(word_valid && word_count == 1, "R1 tick sample count", word_count, 1);
    chk(word_data == 32'h1, "R1 tick sample data", word_data, 32'h1);
    ready_pulse();
    @(negedge clk);
    chk(!word_valid, "R6 consumed", word_valid, 0);

    drive(2'b11); drive(2'b11);
    repeat (20) @(negedge clk);
    drive(2'b10);
    flush_pulse();
    chk(word_count == 2, "R2 unchanged dropped", word_count, 2);
    chk(word_data == 32'hB, "R3 slot order", word_data, 32'hB);
    ready_pulse();

    for (int k = 4; k < 20; k++) drive(gray(k));
    chk(word_valid && word_count == 16, "R4 full count", word_count, 16);
    chk(word_data == exp_word(4, 16), "R3 full data", word_data, exp_word(4, 16));
    for (int k = 20; k < 36; k++) drive(gray(k));
    chk(!overflow, "R7 no early overflow", overflow, 0);
    chk(word_data == exp_word(4, 16), "R6 held word", word_data, exp_word(4, 16));
    drive(gray(36));
    chk(overflow, "R7 overflow set", overflow, 1);
    ready_pulse();
    @(negedge clk);
    chk(word_valid && word_count == 16, "R7 drained count", word_count, 16);
    chk(word_data == exp_word(20, 16), "R7 drained data", word_data, exp_word(20, 16));
    ready_pulse();
    @(negedge clk);
    chk(!word_valid, "R6 second consumed", word_valid, 0);
    chk(overflow, "R7 sticky", overflow, 1);

    for (int k = 37; k < 42; k++) drive(gray(k));
    flush_pulse();
    chk(word_valid && word_count == 5, "R5 partial count", word_count, 5);
    chk(word_data == exp_word(37, 5), "R5 partial data", word_data, exp_word(37, 5));
    ready_pulse();
    flush_pulse();
    chk(!word_valid, "R5 empty flush", word_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule